// File: doc/BRIEF.md
# Dual Wiper Register File Controller

This block keeps the digital state of two digitally controlled potentiometers. Each pot has a volatile 6-bit wiper counter, whose value selects one of 64 taps, and a bank of four 6-bit data registers. The data registers stand in for nonvolatile storage. They are plain flops with an initial value taken from a parameter, and every write into them is followed by a timed busy window.

A serial front end decodes host transactions into one-cycle commands and presents them to this block. The block runs the command in the cycle it is accepted. Commands can read or write a wiper counter or a data register, and can move a value between a data register and a wiper counter, either for one pot or for both pots at once. A command can also step the wiper by one tap.

Writes into the data registers are refused while the active-low write-protect input is low. While the busy window runs, every new command is dropped.

Top module: `dual_wiper_regfile`

## Requirements
- R1: After reset each wiper output equals register R0 of its own pot, as given by `INIT_DR`. Register Rr of pot p sits at bits [(p*4+r)*6 +: 6] of `INIT_DR`. After reset `busy_o` and `rdata_valid_o` are low.
- R2: A command is accepted on a rising clock edge when `cmd_valid_i` is high and `busy_o` is low. Opcode 1 reads the wiper counter of pot `cmd_pot_i`, and opcode 3 reads a data register. After the accepting edge, `rdata_o` holds the value and `rdata_valid_o` is high for one cycle.
- R3: The 2-bit `cmd_sel_i` field selects the data register as follows: 00 selects R0, 10 selects R1, 01 selects R2 and 11 selects R3.
- R4: Opcode 2 loads `cmd_wdata_i` into the selected wiper counter at the accepting edge. It leaves the other pot unchanged and does not raise `busy_o`.
- R5: Opcode 4 writes `cmd_wdata_i` into the selected data register. Unless write protect blocks it, `busy_o` is then high for exactly `BUSY_CYCLES` cycles after the accepting edge.
- R6: Opcode 5 copies the selected data register into the wiper counter of the same pot, with no busy window. Opcode 6 copies the wiper counter into the selected data register and starts the busy window.
- R7: Opcode 7 loads both wiper counters from the selected data register of their own pot. Opcode 8 stores both wiper counters into the selected data register of their own pot and starts the busy window.
- R8: Opcode 9 moves the wiper of the selected pot by one tap, up when `cmd_up_i` is 1 and down when it is 0. The other pot does not change.
- R9: A step never wraps around. An up step at tap 63 leaves the wiper at 63, and a down step at tap 0 leaves it at 0.
- R10: While `busy_o` is high, commands change no register and produce no read data.
- R11: While `wp_ni` is low, opcodes 4, 6 and 8 leave the data registers unchanged and do not raise `busy_o`. Volatile commands still execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 4 | Opcode (0 no-op, 1 to 9 as listed in the requirements) |
| cmd_pot_i | input | 1 | Pot select |
| cmd_sel_i | input | 2 | Data register select |
| cmd_wdata_i | input | 6 | Write value |
| cmd_up_i | input | 1 | Step direction (1 up) |
| wp_ni | input | 1 | Write protect, active low |
| wiper0_o | output | 6 | Wiper position of pot 0 |
| wiper1_o | output | 6 | Wiper position of pot 1 |
| rdata_o | output | 6 | Read data |
| rdata_valid_o | output | 1 | Read data strobe |
| busy_o | output | 1 | Nonvolatile write in progress |

## Verification
Every result is due one rising edge after the accepting edge: the wiper outputs, `rdata_o` with its strobe, and the rise of `busy_o`. The bench drives each command at a falling edge, removes it at the next falling edge, and samples the outputs at that same falling edge, half a period after the accepting edge. The busy window is measured by counting falling edges until `busy_o` drops, and the count is compared with `BUSY_CYCLES`. Data registers are then read back through opcode 3, so transfers and blocked writes are confirmed only at the ports.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  localparam int TAP_W  = 6;
  localparam int NUM_DR = 4;

  typedef enum logic [3:0] {
    OP_NOP       = 4'd0,
    OP_RD_WCR    = 4'd1,
    OP_WR_WCR    = 4'd2,
    OP_RD_DR     = 4'd3,
    OP_WR_DR     = 4'd4,
    OP_DR2WCR    = 4'd5,
    OP_WCR2DR    = 4'd6,
    OP_G_DR2WCR  = 4'd7,
    OP_G_WCR2DR  = 4'd8,
    OP_STEP      = 4'd9
  } op_e;
endpackage

// File: rtl/wiper_busy_timer.sv
module wiper_busy_timer #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (start_i)          cnt_q <= LOAD;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // R5
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_o && cnt_q == LOAD));
endmodule

// File: rtl/wiper_pot_bank.sv
module wiper_pot_bank #(
  parameter int W   = 6,
  parameter int NDR = 4,
  parameter int IW  = $clog2(NDR),
  parameter logic [NDR*W-1:0] INIT = '0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wcr_ld_i,
  input  logic [W-1:0]            wcr_val_i,
  input  logic                    step_i,
  input  logic                    step_up_i,
  input  logic                    dr_wr_i,
  input  logic [IW-1:0]           dr_idx_i,
  input  logic [W-1:0]            dr_val_i,
  output logic [W-1:0]            wcr_o,
  output logic [NDR-1:0][W-1:0]   dr_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0]          wcr_q;
  logic [NDR-1:0][W-1:0] dr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcr_q <= INIT[W-1:0];
      dr_q  <= INIT;
    end else begin
      if (wcr_ld_i) wcr_q <= wcr_val_i;
      else if (step_i) begin
        if (step_up_i && wcr_q != TOP)       wcr_q <= wcr_q + 1'b1;
        else if (!step_up_i && wcr_q != '0)  wcr_q <= wcr_q - 1'b1;
      end
      if (dr_wr_i) dr_q[dr_idx_i] <= dr_val_i;
    end
  end

  assign wcr_o = wcr_q;
  assign dr_o  = dr_q;

  // R8
  step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !wcr_ld_i && step_up_i && wcr_q != TOP) |=> wcr_q == $past(wcr_q) + 1'b1);
  // R9
  sat_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !wcr_ld_i && step_up_i && wcr_q == TOP) |=> wcr_q == TOP);
  // R9
  sat_bot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !wcr_ld_i && !step_up_i && wcr_q == '0) |=> wcr_q == '0);
endmodule

// File: rtl/dual_wiper_regfile.sv
module dual_wiper_regfile
  import wiper_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 625000,
  parameter logic [2*NUM_DR*TAP_W-1:0] INIT_DR = {
    6'd0, 6'd0, 6'd0, 6'd32, 6'd0, 6'd0, 6'd0, 6'd32}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [3:0]       cmd_op_i,
  input  logic             cmd_pot_i,
  input  logic [1:0]       cmd_sel_i,
  input  logic [TAP_W-1:0] cmd_wdata_i,
  input  logic             cmd_up_i,
  input  logic             wp_ni,
  output logic [TAP_W-1:0] wiper0_o,
  output logic [TAP_W-1:0] wiper1_o,
  output logic [TAP_W-1:0] rdata_o,
  output logic             rdata_valid_o,
  output logic             busy_o
);
  localparam int NPOT = 2;
  localparam int BANK = NUM_DR * TAP_W;
  localparam int IW   = $clog2(NUM_DR);

  op_e        op;
  logic       acc, nv_op, nv_go;
  logic [IW-1:0] idx;
  logic [NPOT-1:0][TAP_W-1:0]             wcr;
  logic [NPOT-1:0][NUM_DR-1:0][TAP_W-1:0] dr;

  assign op    = op_e'(cmd_op_i);
  assign acc   = cmd_valid_i && !busy_o;
  // select bits are swapped: 10 -> R1, 01 -> R2
  assign idx   = {cmd_sel_i[0], cmd_sel_i[1]};
  assign nv_op = (op == OP_WR_DR) || (op == OP_WCR2DR) || (op == OP_G_WCR2DR);
  assign nv_go = acc && nv_op && wp_ni;

  for (genvar p = 0; p < NPOT; p++) begin : g_pot
    logic own, wld, dwr;
    logic [TAP_W-1:0] wval, dval;

    always_comb begin
      own  = acc && (cmd_pot_i == 1'(p));
      wld  = 1'b0;
      wval = cmd_wdata_i;
      dwr  = 1'b0;
      dval = cmd_wdata_i;
      if ((own && op == OP_WR_WCR)) begin
        wld = 1'b1;
      end else if ((own && op == OP_DR2WCR) || (acc && op == OP_G_DR2WCR)) begin
        wld  = 1'b1;
        wval = dr[p][idx];
      end
      if (own && op == OP_WR_DR) begin
        dwr = wp_ni;
      end else if ((own && op == OP_WCR2DR) || (acc && op == OP_G_WCR2DR)) begin
        dwr  = wp_ni;
        dval = wcr[p];
      end
    end

    wiper_pot_bank #(
      .W(TAP_W), .NDR(NUM_DR), .IW(IW), .INIT(INIT_DR[p*BANK +: BANK])
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wcr_ld_i  (wld),
      .wcr_val_i (wval),
      .step_i    (own && op == OP_STEP),
      .step_up_i (cmd_up_i),
      .dr_wr_i   (dwr),
      .dr_idx_i  (idx),
      .dr_val_i  (dval),
      .wcr_o     (wcr[p]),
      .dr_o      (dr[p])
    );
  end

  wiper_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (nv_go),
    .busy_o  (busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o       <= '0;
      rdata_valid_o <= 1'b0;
    end else begin
      rdata_valid_o <= acc && (op == OP_RD_WCR || op == OP_RD_DR);
      if (acc && op == OP_RD_WCR)     rdata_o <= wcr[cmd_pot_i];
      else if (acc && op == OP_RD_DR) rdata_o <= dr[cmd_pot_i][idx];
    end
  end

  assign wiper0_o = wcr[0];
  assign wiper1_o = wcr[1];

  // R2
  rd_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o && (cmd_op_i == 4'd1 || cmd_op_i == 4'd3)) |=> rdata_valid_o);
  // R10
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmd_valid_i) |=> ($stable(wiper0_o) && $stable(wiper1_o) && !rdata_valid_o));
  // R11
  wp_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o && !wp_ni) |=> !busy_o);
  // R4
  wcr_wr_nobusy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o && cmd_op_i == 4'd2) |=> !busy_o);
endmodule

// File: tb/dual_wiper_regfile_tb.sv
module dual_wiper_regfile_tb;
  localparam int N = 12;
  localparam logic [47:0] INIT = {6'd20, 6'd63, 6'd1, 6'd40, 6'd62, 6'd33, 6'd17, 6'd5};

  logic clk = 1'b0, rst_n = 1'b0;
  logic cv = 1'b0, pot = 1'b0, up = 1'b0, wp_n = 1'b1;
  logic [3:0] op = '0;
  logic [1:0] sel = '0;
  logic [5:0] wd = '0;
  logic [5:0] w0, w1, rd;
  logic rv, busy;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_wiper_regfile #(.BUSY_CYCLES(N), .INIT_DR(INIT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cv), .cmd_op_i(op), .cmd_pot_i(pot),
    .cmd_sel_i(sel), .cmd_wdata_i(wd), .cmd_up_i(up), .wp_ni(wp_n),
    .wiper0_o(w0), .wiper1_o(w1), .rdata_o(rd), .rdata_valid_o(rv), .busy_o(busy));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, accepted at next posedge, sample at following negedge
  task automatic cmd(logic [3:0] o, logic p, logic [1:0] s, logic [5:0] d, logic u);
    @(negedge clk);
    cv = 1'b1; op = o; pot = p; sel = s; wd = d; up = u;
    @(negedge clk);
    cv = 1'b0; op = '0;
  endtask

  task automatic rd_dr(string req, logic p, logic [1:0] s, int exp);
    cmd(4'd3, p, s, '0, 0);
    chk({req, " rvalid"}, rv, 1);
    chk(req, rd, exp);
  endtask

  task automatic busy_len(string req);
    int n = 0;
    chk({req, " busy rise"}, busy, 1);
    while (busy) begin @(negedge clk); n++; end
    chk({req, " busy length"}, n, N);
  endtask

  task automatic t_reset();
    chk("R1 wiper0", w0, 5);
    chk("R1 wiper1", w1, 40);
    chk("R1 busy", busy, 0);
    chk("R1 rvalid", rv, 0);
  endtask

  task automatic t_read_map();
    rd_dr("R3 sel10->R1", 0, 2'b10, 17);
    rd_dr("R3 sel01->R2", 0, 2'b01, 33);
    rd_dr("R3 sel11->R3", 1, 2'b11, 20);
    rd_dr("R3 sel00->R0", 1, 2'b00, 40);
    @(negedge clk);
    chk("R2 rvalid one cycle", rv, 0);
  endtask

  task automatic t_wcr_write();
    cmd(4'd2, 0, '0, 6'd9, 0);
    chk("R4 wiper0", w0, 9);
    chk("R4 wiper1 kept", w1, 40);
    chk("R4 no busy", busy, 0);
    cmd(4'd1, 0, '0, '0, 0);
    chk("R2 read wcr valid", rv, 1);
    chk("R2 read wcr", rd, 9);
  endtask

  task automatic t_dr_write();
    cmd(4'd4, 1, 2'b01, 6'd7, 0);
    busy_len("R5");
    rd_dr("R5 dr written", 1, 2'b01, 7);
  endtask

  task automatic t_busy_ignore();
    cmd(4'd4, 0, 2'b00, 6'd11, 0);
    chk("R10 busy", busy, 1);
    cmd(4'd2, 1, '0, 6'd3, 0);
    chk("R10 wiper1 kept", w1, 40);
    cmd(4'd1, 1, '0, '0, 0);
    chk("R10 no read", rv, 0);
    while (busy) @(negedge clk);
    chk("R10 wiper1 after", w1, 40);
    rd_dr("R10 dr0 written", 0, 2'b00, 11);
  endtask

  task automatic t_xfer();
    cmd(4'd5, 1, 2'b01, '0, 0);
    chk("R6 dr->wcr", w1, 7);
    chk("R6 no busy", busy, 0);
    cmd(4'd6, 0, 2'b11, '0, 0);
    busy_len("R6");
    rd_dr("R6 wcr->dr", 0, 2'b11, 9);
  endtask

  task automatic t_global();
    cmd(4'd7, 0, 2'b10, '0, 0);
    chk("R7 g wiper0", w0, 17);
    chk("R7 g wiper1", w1, 1);
    chk("R7 no busy", busy, 0);
    cmd(4'd8, 1, 2'b00, '0, 0);
    busy_len("R7");
    rd_dr("R7 g pot0 R0", 0, 2'b00, 17);
    rd_dr("R7 g pot1 R0", 1, 2'b00, 1);
  endtask

  task automatic t_step();
    cmd(4'd9, 0, '0, '0, 1);
    chk("R8 up", w0, 18);
    chk("R8 other kept", w1, 1);
    cmd(4'd9, 1, '0, '0, 0);
    chk("R8 down", w1, 0);
    cmd(4'd9, 1, '0, '0, 0);
    chk("R9 floor", w1, 0);
    cmd(4'd2, 0, '0, 6'd63, 0);
    cmd(4'd9, 0, '0, '0, 1);
    chk("R9 ceiling", w0, 63);
    cmd(4'd9, 0, '0, '0, 0);
    chk("R8 down from top", w0, 62);
  endtask

  task automatic t_wp();
    wp_n = 1'b0;
    cmd(4'd4, 0, 2'b10, 6'd44, 0);
    chk("R11 no busy wr", busy, 0);
    rd_dr("R11 dr kept", 0, 2'b10, 17);
    cmd(4'd8, 0, 2'b01, '0, 0);
    chk("R11 no busy gxfr", busy, 0);
    rd_dr("R11 g kept", 1, 2'b01, 7);
    cmd(4'd2, 0, '0, 6'd30, 0);
    chk("R11 volatile ok", w0, 30);
    wp_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_map();
    t_wcr_write();
    t_dr_write();
    t_busy_ignore();
    t_xfer();
    t_global();
    t_step();
    t_wp();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule